// File: doc/BRIEF.md
# Packed Signed Halving Subtract Unit

This block decodes and executes one packed-byte operation on 32-bit registers. A 32-bit operation word arrives with a one-cycle strobe. A mode input says which of two encodings the word uses: a single-word fixed layout or a two-halfword wide layout. The decoder takes the two source indices from the word and drives them onto two register-file read ports, which return data in the same cycle. It also takes the destination index from the word. Each of the four byte lanes subtracts the second operand's byte from the first operand's byte as signed values and halves the result. The lane keeps the full 9-bit difference and returns its upper eight bits. The halving therefore rounds toward minus infinity and can never overflow.

Condition evaluation is done outside the block and arrives as a single condition-ok bit. One cycle after the strobe, the block drives a registered write port: enable, destination index and packed result. It also drives a registered hit flag, saying the word matched the selected encoding, and a registered unpredictable flag. All four lanes compute on every strobe, so the latency does not depend on the data.

Top module: `pkd_hsub_unit`

## Requirements
- R1: Byte lane i occupies bits [8i+7:8i], for i = 0..3. In that lane, dst_data holds bits [8:1] of the 9-bit signed difference src_a byte minus src_b byte, which equals floor((a-b)/2).
- R2: With wide_sel=0, hit requires all of the following: word[27:20]=0x63, word[7:4]=0xF, and word[31:28] not equal to 0xF. Bits [11:8] take no part in hit. The indices are src_a=[19:16], dst=[15:12] and src_b=[3:0].
- R3: With wide_sel=1, hit requires word[31:20]=0xFAC, word[15:12]=0xF and word[7:4]=0x2. The indices are src_a=[19:16], dst=[11:8] and src_b=[3:0].
- R4: src_a_idx and src_b_idx follow the operation word combinationally, within the same cycle, for the selected mode.
- R5: On a hit, unpred is set when any of the three indices equals 15. A write never targets index 15.
- R6: With wide_sel=0, if word[11:8] is not 0xF, unpred is set and hit stays set.
- R7: dst_we is set only for a strobed word that has hit=1, unpred=0 and cond_ok=1. When cond_ok=0, no write occurs.
- R8: All outputs are registered and appear one cycle after op_valid. res_valid follows op_valid. A synchronous active-high rst clears res_valid, dst_we, hit and unpred.
- R9: The following per-lane corners hold: 0x80-0x7F gives 0x80, 0x7F-0x80 gives 0x7F, and 0xFF-0x00 gives 0xFF.
- R10: dst_idx carries the destination index field of the selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation word strobe |
| op_word | input | 32 | Operation word |
| wide_sel | input | 1 | 0 selects the fixed layout, 1 selects the wide layout |
| cond_ok | input | 1 | Result of the external condition check |
| src_a_idx | output | 4 | Read port A index |
| src_a_data | input | 32 | Read port A data, same cycle |
| src_b_idx | output | 4 | Read port B index |
| src_b_data | input | 32 | Read port B data, same cycle |
| res_valid | output | 1 | Registered strobe |
| dst_we | output | 1 | Destination write enable |
| dst_idx | output | 4 | Destination index |
| dst_data | output | 32 | Packed halved differences |
| hit | output | 1 | Word matched the selected layout |
| unpred | output | 1 | Reserved index used, or should-be-one bits wrong |

## Verification
The hardest case to reach is a word that hits and is also unpredictable. The fixed-layout should-be-one bits are the sharpest example, because hit must stay set while the write is blocked. The stimulus builds fixed-layout words with bits [11:8] cleared, and separately builds words that carry index 15 in each of the three fields. It then checks that hit is high while dst_we is low. The rounding corners are loaded into separate lanes of a single operand pair, so one strobe covers all three at once.

// File: rtl/pkd_hsub_pkg.sv
package pkd_hsub_pkg;

    parameter int LANES   = 4;
    parameter int LANE_W  = 8;
    parameter int IDX_W   = 4;
    parameter int WORD_W  = 32;

    localparam int DATA_W = LANES * LANE_W;
    localparam logic [IDX_W-1:0] IDX_RSVD = {IDX_W{1'b1}};

    // fixed layout: opcode bits [27:20] and [7:4]
    localparam logic [WORD_W-1:0] FIX_MASK = 32'h0FF0_00F0;
    localparam logic [WORD_W-1:0] FIX_VAL  = 32'h0630_00F0;
    // wide layout: [31:20], [15:12], [7:4]
    localparam logic [WORD_W-1:0] WID_MASK = 32'hFFF0_F0F0;
    localparam logic [WORD_W-1:0] WID_VAL  = 32'hFAC0_F020;

    typedef enum logic {
        ENC_FIXED = 1'b0,
        ENC_WIDE  = 1'b1
    } enc_mode_e;

    typedef struct packed {
        logic [IDX_W-1:0] src_a;
        logic [IDX_W-1:0] src_b;
        logic [IDX_W-1:0] dst;
        logic             hit;
        logic             unpred;
    } dec_t;

    typedef struct packed {
        logic              vld;
        logic              we;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
        logic              hit;
        logic              unpred;
    } out_t;

endpackage

// File: rtl/pkd_hsub_decode.sv
module pkd_hsub_decode
    import pkd_hsub_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  enc_mode_e         mode,
    output dec_t              dec
);

    logic fix_hit, wid_hit, fix_sbo_bad;
    logic [IDX_W-1:0] dst_sel;
    logic any_rsvd;

    always_comb begin
        fix_hit     = ((word & FIX_MASK) == FIX_VAL) && (word[31:28] != 4'hF);
        wid_hit     = ((word & WID_MASK) == WID_VAL);
        fix_sbo_bad = (word[11:8] != 4'hF);

        dst_sel     = (mode == ENC_WIDE) ? word[11:8] : word[15:12];

        dec.src_a   = word[19:16];
        dec.src_b   = word[3:0];
        dec.dst     = dst_sel;
        dec.hit     = (mode == ENC_WIDE) ? wid_hit : fix_hit;

        any_rsvd    = (word[19:16] == IDX_RSVD) || (word[3:0] == IDX_RSVD)
                   || (dst_sel == IDX_RSVD);
        dec.unpred  = dec.hit && (any_rsvd || ((mode == ENC_FIXED) && fix_sbo_bad));
    end

endmodule

// File: rtl/pkd_hsub_lane.sv
module pkd_hsub_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] r
);

    logic [W:0] diff;

    always_comb begin
        diff = {a[W-1], a} - {b[W-1], b};
        r    = diff[W:1];
    end

endmodule

// File: rtl/pkd_hsub_unit.sv
module pkd_hsub_unit
    import pkd_hsub_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [31:0]       op_word,
    input  logic              wide_sel,
    input  logic              cond_ok,
    output logic [3:0]        src_a_idx,
    input  logic [31:0]       src_a_data,
    output logic [3:0]        src_b_idx,
    input  logic [31:0]       src_b_data,
    output logic              res_valid,
    output logic              dst_we,
    output logic [3:0]        dst_idx,
    output logic [31:0]       dst_data,
    output logic              hit,
    output logic              unpred
);

    dec_t              dec;
    logic [DATA_W-1:0] lane_res;
    out_t              st_d, st_q;

    pkd_hsub_decode u_dec (
        .word (op_word),
        .mode (enc_mode_e'(wide_sel)),
        .dec  (dec)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pkd_hsub_lane #(.W(LANE_W)) u_lane (
            .a (src_a_data[g*LANE_W +: LANE_W]),
            .b (src_b_data[g*LANE_W +: LANE_W]),
            .r (lane_res[g*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        st_d        = '0;
        st_d.vld    = op_valid;
        st_d.hit    = op_valid && dec.hit;
        st_d.unpred = op_valid && dec.unpred;
        st_d.we     = op_valid && dec.hit && !dec.unpred && cond_ok;
        st_d.idx    = dec.dst;
        st_d.data   = lane_res;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign src_a_idx = dec.src_a;
    assign src_b_idx = dec.src_b;
    assign res_valid = st_q.vld;
    assign dst_we    = st_q.we;
    assign dst_idx   = st_q.idx;
    assign dst_data  = st_q.data;
    assign hit       = st_q.hit;
    assign unpred    = st_q.unpred;

endmodule

// File: rtl/pkd_hsub_chk.sv
module pkd_hsub_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic        cond_ok,
    input logic [31:0] src_a_data,
    input logic [31:0] src_b_data,
    input logic        res_valid,
    input logic        dst_we,
    input logic [3:0]  dst_idx,
    input logic [31:0] dst_data,
    input logic        hit,
    input logic        unpred
);

    AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        dst_we |-> (hit && !unpred && res_valid)); // R7
    AST_WE_COND: assert property (@(posedge clk) disable iff (rst)
        dst_we |-> $past(cond_ok)); // R7
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!res_valid && !dst_we && !hit)); // R8
    AST_NO_RSVD_WRITE: assert property (@(posedge clk) disable iff (rst)
        dst_we |-> (dst_idx != 4'hF)); // R5
    AST_LANE0_SIGN: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (dst_data[7] == $past($signed(src_a_data[7:0]) < $signed(src_b_data[7:0])))); // R1

endmodule

bind pkd_hsub_unit pkd_hsub_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .cond_ok    (cond_ok),
    .src_a_data (src_a_data),
    .src_b_data (src_b_data),
    .res_valid  (res_valid),
    .dst_we     (dst_we),
    .dst_idx    (dst_idx),
    .dst_data   (dst_data),
    .hit        (hit),
    .unpred     (unpred)
);

// File: tb/pkd_hsub_unit_bench.sv
module pkd_hsub_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, wide_sel, cond_ok;
    logic [31:0] op_word;
    logic [3:0]  src_a_idx, src_b_idx, dst_idx;
    logic [31:0] src_a_data, src_b_data, dst_data;
    logic        res_valid, dst_we, hit, unpred;
    logic [31:0] regs [16];
    int          n_chk = 0, n_err = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    assign src_a_data = regs[src_a_idx];
    assign src_b_data = regs[src_b_idx];

    pkd_hsub_unit u_pkd_hsub_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word),
        .wide_sel(wide_sel), .cond_ok(cond_ok),
        .src_a_idx(src_a_idx), .src_a_data(src_a_data),
        .src_b_idx(src_b_idx), .src_b_data(src_b_data),
        .res_valid(res_valid), .dst_we(dst_we), .dst_idx(dst_idx),
        .dst_data(dst_data), .hit(hit), .unpred(unpred)
    );

    function automatic logic [31:0] fix_word(logic [3:0] c, logic [3:0] n, logic [3:0] d,
                                             logic [3:0] sbo, logic [3:0] m);
        return {c, 8'h63, n, d, sbo, 4'hF, m};
    endfunction

    function automatic logic [31:0] wid_word(logic [3:0] n, logic [3:0] d, logic [3:0] m);
        return {12'hFAC, n, 4'hF, d, 4'h2, m};
    endfunction

    function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) begin
            int da, db, q;
            da = $signed(a[8*i +: 8]);
            db = $signed(b[8*i +: 8]);
            q  = (da - db) >>> 1;
            r[8*i +: 8] = q[7:0];
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, sample next negedge (one register on the path)
    task automatic issue(input logic [31:0] w, input logic mode, input logic cp);
        @(negedge clk);
        op_valid = 1'b1; op_word = w; wide_sel = mode; cond_ok = cp;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; op_valid = 1'b0; op_word = '0; wide_sel = 1'b0; cond_ok = 1'b0;
        repeat (3) @(negedge clk);
        chk(!res_valid && !dst_we && !hit && !unpred, "R8 reset", {28'd0, res_valid, dst_we, hit, unpred}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_fixed_corners();
        regs[1] = 32'h80_7F_FF_10;
        regs[3] = 32'h7F_80_00_20;
        @(negedge clk);
        op_word = fix_word(4'hE, 4'd1, 4'd2, 4'hF, 4'd3); wide_sel = 1'b0; cond_ok = 1'b1; op_valid = 1'b1;
        #1;
        chk(src_a_idx == 4'd1, "R4 fixed src_a", {28'd0, src_a_idx}, 32'd1);
        chk(src_b_idx == 4'd3, "R4 fixed src_b", {28'd0, src_b_idx}, 32'd3);
        @(negedge clk);
        op_valid = 1'b0;
        chk(res_valid && hit && !unpred, "R2 fixed hit", {29'd0, res_valid, hit, unpred}, 32'd6);
        chk(dst_we && dst_idx == 4'd2, "R10 fixed dst", {27'd0, dst_we, dst_idx}, 32'h12);
        chk(dst_data == 32'h80_7F_FF_F8, "R9 corners", dst_data, 32'h80_7F_FF_F8);
        chk(dst_data == model(regs[1], regs[3]), "R1 fixed lanes", dst_data, model(regs[1], regs[3]));
        @(negedge clk);
        chk(!res_valid && !dst_we, "R8 single pulse", {30'd0, res_valid, dst_we}, 32'd0);
    endtask

    task automatic t_wide();
        regs[4] = 32'h01_FE_40_C0;
        regs[9] = 32'hFF_01_C0_40;
        @(negedge clk);
        op_word = wid_word(4'd9, 4'd7, 4'd4); wide_sel = 1'b1; cond_ok = 1'b1; op_valid = 1'b1;
        #1;
        chk(src_a_idx == 4'd9 && src_b_idx == 4'd4, "R4 wide indices", {24'd0, src_a_idx, src_b_idx}, 32'h94);
        @(negedge clk);
        op_valid = 1'b0;
        chk(hit && !unpred && dst_we, "R3 wide hit", {29'd0, hit, unpred, dst_we}, 32'd5);
        chk(dst_idx == 4'd7, "R10 wide dst", {28'd0, dst_idx}, 32'd7);
        chk(dst_data == model(regs[9], regs[4]), "R1 wide lanes", dst_data, model(regs[9], regs[4]));
    endtask

    task automatic t_cond_fail();
        issue(fix_word(4'h0, 4'd1, 4'd2, 4'hF, 4'd3), 1'b0, 1'b0);
        chk(res_valid && hit && !dst_we, "R7 cond fail", {29'd0, res_valid, hit, dst_we}, 32'd6);
    endtask

    task automatic t_reserved();
        issue(fix_word(4'hE, 4'd1, 4'hF, 4'hF, 4'd3), 1'b0, 1'b1);
        chk(hit && unpred && !dst_we, "R5 dst 15", {29'd0, hit, unpred, dst_we}, 32'd6);
        issue(wid_word(4'hF, 4'd2, 4'd3), 1'b1, 1'b1);
        chk(hit && unpred && !dst_we, "R5 src_a 15", {29'd0, hit, unpred, dst_we}, 32'd6);
        issue(wid_word(4'd1, 4'd2, 4'hF), 1'b1, 1'b1);
        chk(hit && unpred && !dst_we, "R5 src_b 15", {29'd0, hit, unpred, dst_we}, 32'd6);
    endtask

    task automatic t_sbo();
        issue(fix_word(4'hE, 4'd1, 4'd2, 4'h0, 4'd3), 1'b0, 1'b1);
        chk(hit && unpred && !dst_we, "R6 sbo zero", {29'd0, hit, unpred, dst_we}, 32'd6);
        issue(fix_word(4'hE, 4'd1, 4'd2, 4'h7, 4'd3), 1'b0, 1'b1);
        chk(hit && unpred && !dst_we, "R6 sbo partial", {29'd0, hit, unpred, dst_we}, 32'd6);
    endtask

    task automatic t_nomatch();
        issue(fix_word(4'hF, 4'd1, 4'd2, 4'hF, 4'd3), 1'b0, 1'b1);
        chk(!hit && !dst_we, "R2 cond 1111", {30'd0, hit, dst_we}, 32'd0);
        issue(fix_word(4'hE, 4'd1, 4'd2, 4'hF, 4'd3) ^ 32'h0000_0010, 1'b0, 1'b1);
        chk(!hit && !dst_we, "R2 bit4 wrong", {30'd0, hit, dst_we}, 32'd0);
        issue(wid_word(4'd1, 4'd2, 4'd3), 1'b0, 1'b1);
        chk(!hit && !dst_we, "R2 wide word in fixed mode", {30'd0, hit, dst_we}, 32'd0);
        issue(fix_word(4'hE, 4'd1, 4'd2, 4'hF, 4'd3), 1'b1, 1'b1);
        chk(!hit && !dst_we, "R3 fixed word in wide mode", {30'd0, hit, dst_we}, 32'd0);
        issue(wid_word(4'd1, 4'd2, 4'd3) | 32'h0000_0040, 1'b1, 1'b1);
        chk(!hit && !dst_we, "R3 unsigned bit set", {30'd0, hit, dst_we}, 32'd0);
    endtask

    task automatic t_sweep();
        logic [31:0] s = 32'h1234_5678;
        for (int k = 0; k < 20; k++) begin
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            regs[5] = s;
            regs[6] = {s[15:0], s[31:16]} ^ 32'hA5A5_5A5A;
            issue(wid_word(4'd5, 4'd8, 4'd6), 1'b1, 1'b1);
            chk(dst_we && dst_data == model(regs[5], regs[6]), "R1 sweep", dst_data, model(regs[5], regs[6]));
        end
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        op_word = fix_word(4'hE, 4'd1, 4'd2, 4'hF, 4'd3); wide_sel = 1'b0; cond_ok = 1'b1;
        op_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        op_valid = 1'b0; rst = 1'b0;
        chk(!res_valid && !dst_we, "R8 reset wins", {30'd0, res_valid, dst_we}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 32'h0101_0101 * i;
        t_reset();
        t_fixed_corners();
        t_wide();
        t_cond_fail();
        t_reserved();
        t_sbo();
        t_nomatch();
        t_sweep();
        t_mid_reset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule